// File: doc/BRIEF.md
# GPIO Wake Event Controller

This block watches twelve general-purpose input pins and turns chosen transitions on them into sticky wake-event status bits. The pins are split into an eight-pin group A and a four-pin group B. Each group has its own status and enable register. A per-pin polarity bit picks whether a rising or a falling edge counts. Two pins of group B can be switched into a both-edge mode, where any transition counts. Those two pins also report every transition into a separate aggregate status register.

Status bits latch whether or not they are enabled, and software clears them by writing ones. One power-management event output asserts while the global enable is on and at least one status bit has its enable bit set. The active level of this output and its drive style (open-drain or push-pull) are programmable. A byte-wide register port with single-cycle read and write strobes gives access to every register. Inputs pass through a synchronizer before edge detection.

Top module: `gpio_wake_ctrl`

## Requirements
- R1: After reset every polarity bit is 0 and a rising edge on a pin sets its status bit. Pins 0..7 map to bits 0..7 of status A (address 0x0). Pins 8..11 map to bits 0..3 of status B (address 0x1). A falling edge leaves the bit clear.
- R2: With the pin's polarity bit set to 1 (polarity A at 0x4 for pins 0..7, polarity B at 0x5 bits 0..3 for pins 8..11), a falling edge sets the status bit and a rising edge does not.
- R3: Status bits latch even when their enable bit (enable A 0x2, enable B 0x3) is 0. The event is asserted only when the global enable (output control 0x7 bit 0) is 1 and some status bit has its enable bit set.
- R4: Writing a 1 to a status bit clears it. Writing a 0 leaves it unchanged. Status bits change only through an edge or such a write.
- R5: An edge that would set a status bit in the same cycle as a write-one clear of that bit leaves the bit set.
- R6: Mode register (0x6) bit 0 puts pin 9 into both-edge mode, and bit 1 does the same for pin 10. In that mode both rising and falling edges set the status bit, whatever the polarity bit says.
- R7: The pin data registers (0x9 for pins 0..7, 0xA bits 0..3 for pins 8..11) read the synchronized pin level XOR the polarity bit, in both-edge mode as well.
- R8: Any transition on pin 9 sets aggregate status (0x8) bit 0, and any transition on pin 10 sets bit 1. This happens whether or not both-edge mode or the enables are set. These bits are cleared by writing 1.
- R9: Output control bit 1 selects active high (1) or active low (0), and bit 7 selects push-pull (1) or open-drain (0). Both reset to 0. In open-drain mode the output enable is 1 only while the event is asserted, and the data then equals the active level.
- R10: In push-pull mode the output enable is always 1. The data equals the active level while the event is asserted and its inverse otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 12 | Wake-capable pin inputs (asynchronous) |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_we | input | 1 | Single-cycle write strobe |
| reg_re | input | 1 | Read strobe; read data is zero when low |
| reg_rdata | output | 8 | Read data (combinational from address) |
| evt_o | output | 1 | Power-management event data |
| evt_oe_o | output | 1 | Power-management event output enable |

## Verification
The bench lines up a pin edge with a write-one clear of the same bit in the same clock. A design that lets the clear win would lose a wake event. It toggles both-edge pins with their polarity bit set, which catches a design that still filters by direction. It also checks that the data readback stays inverted in that mode. It moves the aggregate bits with the mode and enables off, which exposes a design that latches them only when enabled. Finally it checks the output in both drive styles and at both levels. An inverted level or an enable that is always driven in open-drain mode shows up at the pins.

// File: rtl/gwk_pkg.sv
package gwk_pkg;
    localparam int unsigned GA_W   = 8;
    localparam int unsigned GB_W   = 4;
    localparam int unsigned PIN_W  = GA_W + GB_W;
    localparam int unsigned ADDR_W = 4;
    localparam int unsigned DATA_W = 8;
    localparam int unsigned BE_N   = 2;

    localparam logic [ADDR_W-1:0] A_STS_A  = 4'h0;
    localparam logic [ADDR_W-1:0] A_STS_B  = 4'h1;
    localparam logic [ADDR_W-1:0] A_EN_A   = 4'h2;
    localparam logic [ADDR_W-1:0] A_EN_B   = 4'h3;
    localparam logic [ADDR_W-1:0] A_POL_A  = 4'h4;
    localparam logic [ADDR_W-1:0] A_POL_B  = 4'h5;
    localparam logic [ADDR_W-1:0] A_MODE   = 4'h6;
    localparam logic [ADDR_W-1:0] A_OUTCTL = 4'h7;
    localparam logic [ADDR_W-1:0] A_AGG    = 4'h8;
    localparam logic [ADDR_W-1:0] A_DAT_A  = 4'h9;
    localparam logic [ADDR_W-1:0] A_DAT_B  = 4'hA;

    typedef struct packed {
        logic [GA_W-1:0] sts_a;
        logic [GB_W-1:0] sts_b;
        logic [GA_W-1:0] en_a;
        logic [GB_W-1:0] en_b;
        logic [GA_W-1:0] pol_a;
        logic [GB_W-1:0] pol_b;
        logic [BE_N-1:0] mode;
        logic [BE_N-1:0] agg;
        logic            gen;
        logic            act_hi;
        logic            push_pull;
    } gwk_state_t;
endpackage

// File: rtl/gwk_sync.sv
module gwk_sync #(
    parameter int unsigned W      = 12,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage_q[s] <= '0;
                end else if (s == 0) begin
                    stage_q[s] <= din;
                end else begin
                    stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/gwk_edge.sv
module gwk_edge #(
    parameter int unsigned W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    input  logic [W-1:0] pol,
    input  logic [W-1:0] both,
    output logic [W-1:0] hit,
    output logic [W-1:0] chg
);
    logic [W-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    generate
        for (genvar i = 0; i < W; i++) begin : g_pin
            always_comb begin
                chg[i] = lvl[i] ^ prev_q[i];
                if (both[i])     hit[i] = chg[i];
                else if (pol[i]) hit[i] = ~lvl[i] & prev_q[i];
                else             hit[i] = lvl[i] & ~prev_q[i];
            end
        end
    endgenerate

    AST_HIT_NEEDS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (hit & ~(lvl ^ $past(lvl))) == '0) // R6
        else $error("hit without a level change");
endmodule

// File: rtl/gwk_outdrv.sv
module gwk_outdrv (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic act_hi,
    input  logic push_pull,
    output logic evt_o,
    output logic evt_oe_o
);
    always_comb begin
        if (push_pull) begin
            evt_oe_o = 1'b1;
            evt_o    = active ? act_hi : ~act_hi;
        end else begin
            evt_oe_o = active;
            evt_o    = act_hi;
        end
    end

    AST_OD_FLOATS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!push_pull && !active) |-> !evt_oe_o) // R9
        else $error("open-drain output driven while idle");
    AST_PP_ALWAYS_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        push_pull |-> evt_oe_o) // R10
        else $error("push-pull output not driven");
endmodule

// File: rtl/gpio_wake_ctrl.sv
module gpio_wake_ctrl
    import gwk_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned BE_PIN0     = 1,
    parameter int unsigned BE_PIN1     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PIN_W-1:0]  pin_i,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              reg_we,
    input  logic              reg_re,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              evt_o,
    output logic              evt_oe_o
);
    localparam int unsigned BE_IDX0 = GA_W + BE_PIN0;
    localparam int unsigned BE_IDX1 = GA_W + BE_PIN1;

    gwk_state_t st_d, st_q;
    logic [PIN_W-1:0] lvl, hit, chg, be_sel, pol_all;
    logic [GA_W-1:0]  clr_a;
    logic [GB_W-1:0]  clr_b;
    logic [BE_N-1:0]  clr_agg, agg_hit;
    logic             evt_active;

    gwk_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(pin_i), .dout(lvl)
    );

    always_comb begin
        be_sel          = '0;
        be_sel[BE_IDX0] = st_q.mode[0];
        be_sel[BE_IDX1] = st_q.mode[1];
        pol_all         = {st_q.pol_b, st_q.pol_a};
    end

    gwk_edge #(.W(PIN_W)) u_edge (
        .clk(clk), .rst_n(rst_n), .lvl(lvl), .pol(pol_all),
        .both(be_sel), .hit(hit), .chg(chg)
    );

    always_comb begin
        st_d    = st_q;
        clr_a   = (reg_we && reg_addr == A_STS_A) ? reg_wdata : '0;
        clr_b   = (reg_we && reg_addr == A_STS_B) ? reg_wdata[GB_W-1:0] : '0;
        clr_agg = (reg_we && reg_addr == A_AGG) ? reg_wdata[BE_N-1:0] : '0;
        agg_hit = {chg[BE_IDX1], chg[BE_IDX0]};

        st_d.sts_a = (st_q.sts_a & ~clr_a) | hit[GA_W-1:0];
        st_d.sts_b = (st_q.sts_b & ~clr_b) | hit[PIN_W-1:GA_W];
        st_d.agg   = (st_q.agg & ~clr_agg) | agg_hit;

        if (reg_we) begin
            case (reg_addr)
                A_EN_A:   st_d.en_a  = reg_wdata;
                A_EN_B:   st_d.en_b  = reg_wdata[GB_W-1:0];
                A_POL_A:  st_d.pol_a = reg_wdata;
                A_POL_B:  st_d.pol_b = reg_wdata[GB_W-1:0];
                A_MODE:   st_d.mode  = reg_wdata[BE_N-1:0];
                A_OUTCTL: begin
                    st_d.gen       = reg_wdata[0];
                    st_d.act_hi    = reg_wdata[1];
                    st_d.push_pull = reg_wdata[7];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_re) begin
            case (reg_addr)
                A_STS_A:  reg_rdata = st_q.sts_a;
                A_STS_B:  reg_rdata = {{(DATA_W-GB_W){1'b0}}, st_q.sts_b};
                A_EN_A:   reg_rdata = st_q.en_a;
                A_EN_B:   reg_rdata = {{(DATA_W-GB_W){1'b0}}, st_q.en_b};
                A_POL_A:  reg_rdata = st_q.pol_a;
                A_POL_B:  reg_rdata = {{(DATA_W-GB_W){1'b0}}, st_q.pol_b};
                A_MODE:   reg_rdata = {{(DATA_W-BE_N){1'b0}}, st_q.mode};
                A_OUTCTL: reg_rdata = {st_q.push_pull, 5'b0, st_q.act_hi, st_q.gen};
                A_AGG:    reg_rdata = {{(DATA_W-BE_N){1'b0}}, st_q.agg};
                A_DAT_A:  reg_rdata = lvl[GA_W-1:0] ^ st_q.pol_a;
                A_DAT_B:  reg_rdata = {{(DATA_W-GB_W){1'b0}}, lvl[PIN_W-1:GA_W] ^ st_q.pol_b};
                default:  reg_rdata = '0;
            endcase
        end
    end

    assign evt_active = st_q.gen &
        (|({st_q.sts_b, st_q.sts_a} & {st_q.en_b, st_q.en_a}));

    gwk_outdrv u_out (
        .clk(clk), .rst_n(rst_n), .active(evt_active), .act_hi(st_q.act_hi),
        .push_pull(st_q.push_pull), .evt_o(evt_o), .evt_oe_o(evt_oe_o)
    );

    AST_STS_ONLY_BY_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        ({st_q.sts_b, st_q.sts_a} & ~$past({st_q.sts_b, st_q.sts_a}) & ~$past(hit)) == '0) // R1
        else $error("status set without an edge");
    AST_STS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ((~st_q.sts_a & $past(st_q.sts_a)) != '0) |->
        ($past(reg_we) && $past(reg_addr) == A_STS_A)) // R4
        else $error("status A bit dropped without a clear write");
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(reg_we) && $past(reg_addr) == A_STS_A) |->
        ((st_q.sts_a & $past(reg_wdata) & ~$past(hit[GA_W-1:0])) == '0)) // R4
        else $error("write-one did not clear status A");
    AST_EDGE_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.sts_a & $past(hit[GA_W-1:0])) == $past(hit[GA_W-1:0]))) // R5
        else $error("edge lost against a clear");
    AST_AGG_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        $past(chg[BE_IDX0]) |-> st_q.agg[0]) // R8
        else $error("aggregate bit missed a transition");
endmodule

// File: tb/gpio_wake_ctrl_bench.sv
module gpio_wake_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] pin_i = '0;
    logic [3:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic        reg_we = 1'b0;
    logic        reg_re = 1'b0;
    logic [7:0]  reg_rdata;
    logic        evt_o, evt_oe_o;
    int          n_checks = 0;
    int          n_errors = 0;
    logic [7:0]  rv;

    always #2.5 clk = ~clk;

    gpio_wake_ctrl u_gpio_wake_ctrl (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_re(reg_re),
        .reg_rdata(reg_rdata), .evt_o(evt_o), .evt_oe_o(evt_oe_o)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_re = 1'b1;
        #1 d = reg_rdata;
        reg_re = 1'b0;
    endtask

    task automatic set_pin(input int idx, input logic v);
        @(negedge clk);
        pin_i[idx] = v;
        repeat (4) @(posedge clk);
    endtask

    task automatic t_reset;
        rd(4'h0, rv); check("R1 reset status A", rv, 8'h00);
        rd(4'h7, rv); check("R9 reset output control", rv, 8'h00);
        @(negedge clk); #1;
        check("R9 reset open-drain idle oe", {7'b0, evt_oe_o}, 8'h00);
    endtask

    task automatic t_rise_default;
        set_pin(3, 1'b1);
        rd(4'h0, rv); check("R1 rising edge pin 3", rv, 8'h08);
        set_pin(8, 1'b1);
        rd(4'h1, rv); check("R1 rising edge pin 8", rv, 8'h01);
        wr(4'h0, 8'hFF); wr(4'h1, 8'h0F);
        set_pin(3, 1'b0);
        rd(4'h0, rv); check("R1 falling edge ignored", rv, 8'h00);
        set_pin(8, 1'b0);
        wr(4'h1, 8'h0F);
    endtask

    task automatic t_falling_pol;
        wr(4'h4, 8'h20);
        set_pin(5, 1'b1);
        rd(4'h0, rv); check("R2 rising ignored with polarity 1", rv, 8'h00);
        set_pin(5, 1'b0);
        rd(4'h0, rv); check("R2 falling sets with polarity 1", rv, 8'h20);
        wr(4'h0, 8'hFF); wr(4'h4, 8'h00);
    endtask

    task automatic t_enable;
        set_pin(1, 1'b1);
        rd(4'h0, rv); check("R3 latch while disabled", rv, 8'h02);
        @(negedge clk); #1;
        check("R3 no event while disabled", {7'b0, evt_oe_o}, 8'h00);
        wr(4'h2, 8'h02);
        #1 check("R3 no event without global enable", {7'b0, evt_oe_o}, 8'h00);
        wr(4'h7, 8'h01);
        #1 check("R9 open-drain active low drives 0", {6'b0, evt_oe_o, evt_o}, 8'h02);
        wr(4'h2, 8'h00);
        #1 check("R3 enable off drops event", {7'b0, evt_oe_o}, 8'h00);
        wr(4'h7, 8'h03); wr(4'h2, 8'h02);
        #1 check("R9 open-drain active high drives 1", {6'b0, evt_oe_o, evt_o}, 8'h03);
        wr(4'h2, 8'h00); wr(4'h7, 8'h00);
    endtask

    task automatic t_w1c;
        set_pin(6, 1'b1);
        rd(4'h0, rv); check("R4 setup two bits", rv, 8'h42);
        wr(4'h0, 8'h00);
        rd(4'h0, rv); check("R4 write zero keeps", rv, 8'h42);
        wr(4'h0, 8'h40);
        rd(4'h0, rv); check("R4 write one clears one bit", rv, 8'h02);
        wr(4'h0, 8'hFF);
        set_pin(1, 1'b0); set_pin(6, 1'b0);
    endtask

    task automatic t_race;
        set_pin(0, 1'b1);
        set_pin(0, 1'b0);
        rd(4'h0, rv); check("R5 setup bit set", rv, 8'h01);
        @(negedge clk);
        pin_i[0] = 1'b1;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        reg_addr = 4'h0; reg_wdata = 8'h01; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
        rd(4'h0, rv); check("R5 edge wins over clear", rv, 8'h01);
        wr(4'h0, 8'h01);
        rd(4'h0, rv); check("R4 later clear works", rv, 8'h00);
        set_pin(0, 1'b0);
    endtask

    task automatic t_both_edge;
        wr(4'h6, 8'h01); wr(4'h5, 8'h02);
        set_pin(9, 1'b1);
        rd(4'h1, rv); check("R6 both-edge rising with polarity 1", rv, 8'h02);
        rd(4'hA, rv); check("R7 readback inverted in both-edge mode", rv, 8'h00);
        wr(4'h1, 8'h0F);
        set_pin(9, 1'b0);
        rd(4'h1, rv); check("R6 both-edge falling", rv, 8'h02);
        wr(4'h1, 8'h0F); wr(4'h8, 8'h03);
        set_pin(10, 1'b1);
        rd(4'h1, rv); check("R6 pin 10 rising, normal mode", rv, 8'h04);
        wr(4'h1, 8'h0F);
        set_pin(10, 1'b0);
        rd(4'h1, rv); check("R6 pin 10 falling ignored without mode", rv, 8'h00);
        wr(4'h5, 8'h00);
        rd(4'hA, rv); check("R7 readback polarity 0", rv, 8'h00);
        set_pin(9, 1'b1);
        rd(4'hA, rv); check("R7 readback high", rv, 8'h02);
        set_pin(9, 1'b0);
        wr(4'h6, 8'h00); wr(4'h1, 8'h0F); wr(4'h8, 8'h03);
    endtask

    task automatic t_agg;
        set_pin(10, 1'b1);
        rd(4'h8, rv); check("R8 aggregate set without mode", rv, 8'h02);
        set_pin(9, 1'b1);
        rd(4'h8, rv); check("R8 aggregate both bits", rv, 8'h03);
        wr(4'h8, 8'h00);
        rd(4'h8, rv); check("R8 write zero keeps", rv, 8'h03);
        wr(4'h8, 8'h02);
        rd(4'h8, rv); check("R8 write one clears", rv, 8'h01);
        set_pin(9, 1'b0); set_pin(10, 1'b0);
        wr(4'h8, 8'h03); wr(4'h1, 8'h0F);
    endtask

    task automatic t_pushpull;
        wr(4'h7, 8'h83);
        #1 check("R10 push-pull idle drives inactive", {6'b0, evt_oe_o, evt_o}, 8'h02);
        wr(4'h3, 8'h08);
        set_pin(11, 1'b1);
        #1 check("R10 push-pull active high", {6'b0, evt_oe_o, evt_o}, 8'h03);
        wr(4'h7, 8'h81);
        #1 check("R10 push-pull active low", {6'b0, evt_oe_o, evt_o}, 8'h02);
        wr(4'h1, 8'h08);
        #1 check("R10 push-pull active low idle", {6'b0, evt_oe_o, evt_o}, 8'h03);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        t_reset();
        t_rise_default();
        t_falling_pol();
        t_enable();
        t_w1c();
        t_race();
        t_both_edge();
        t_agg();
        t_pushpull();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule